// File: doc/BRIEF.md
# Calendar Register File with Deferred Commit

This block keeps the time of day and the calendar date as two packed 32-bit words and advances them on a one-cycle seconds tick. Seconds, minutes and hours roll into the day, and the day rolls over using the length of the current month. The year is a 6-bit offset from 1970, and the date word carries an explicit leap-year flag.

Software loads either word through a small write port. A write does not take effect at once. It is parked in a holding register, and the busy bit for that word stays set until the value has been moved into the timekeeping state. That happens on the second tick after the write. While a word is busy, further writes to it are dropped, so software has to poll the busy bits before it writes.

Top module: `cal_regs`

## Requirements
- R1: After reset, time_o is 0 (00:00:00), date_o is 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and busy_o is 0.
- R2: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. On each tick the seconds advance, wrapping from 59 to 0. Minutes advance on that wrap and also wrap from 59 to 0. Hours advance when minutes wrap and go from 23 to 0.
- R3: The date word holds the day in bits 4:0, the 1-based month in bits 11:8, the year offset in bits 21:16 and the leap flag in bit 22. The date advances only on the tick where the hours wrap. A day past the month length (30 for months 4, 6, 9 and 11, 31 otherwise) returns to 1 and advances the month. Month 12 goes to month 1 and advances the year, and the year offset wraps from 63 to 0.
- R4: February has 29 days when the leap flag is 1 and 28 days when it is 0. When the year advances, the leap flag becomes 1 exactly when (offset + 1970) mod 4 is 0. Otherwise the flag keeps its value.
- R5: A write with wr_sel_i = 0 targets the time word and one with wr_sel_i = 1 targets the date word. If that word is idle, the write sets its busy bit from the next cycle on: busy_o[1] for time, busy_o[0] for date.
- R6: A write to a word whose busy bit is set has no effect on the value that is later committed.
- R7: The commit happens on the second tick strictly after the write cycle. On that edge the busy bit clears and the word takes the written value, with every bit outside its fields forced to 0. On that tick the committed word does not advance.
- R8: time_o and date_o change only on clock edges where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Word select: 0 = time, 1 = date |
| wr_data_i | input | 32 | Write data in packed layout |
| time_o | output | 32 | Packed time word |
| date_o | output | 32 | Packed date word |
| busy_o | output | 2 | Pending-commit flags: [1] time, [0] date |

## Verification
The bench loads times and dates that sit on every rollover boundary and checks each one a single tick later. The boundaries cover the end of February in leap and non-leap years, a 29th of February, the ends of 30-day and 31-day months, the end of the year, and the wrap of the year offset from 63 to 0. A design with the wrong month-length table, or with the leap rule applied with the wrong offset, shows up as a wrong day or a wrong flag. Directed tests cover the commit timing. They include a tick in the same cycle as the write, which must not count towards the commit. They include a second write made while busy, which must be dropped; a design that accepted it would show the later value. They include a write with stray high bits, which a design without masking would pass through to the word.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] TIME_MASK  = 32'h001F_3F3F;
  localparam logic [WORD_W-1:0] DATE_MASK  = 32'h007F_0F1F;
  localparam logic [WORD_W-1:0] DATE_RESET = 32'h0000_0101;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } time_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] year;
    logic [3:0] mon;
    logic [4:0] day;
  } date_t;

  function automatic time_t unpack_time(logic [WORD_W-1:0] w);
    unpack_time.hour = w[20:16];
    unpack_time.min  = w[13:8];
    unpack_time.sec  = w[5:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_time(time_t t);
    pack_time = {11'd0, t.hour, 2'd0, t.min, 2'd0, t.sec};
  endfunction

  function automatic date_t unpack_date(logic [WORD_W-1:0] w);
    unpack_date.leap = w[22];
    unpack_date.year = w[21:16];
    unpack_date.mon  = w[11:8];
    unpack_date.day  = w[4:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_date(date_t d);
    pack_date = {9'd0, d.leap, d.year, 4'd0, d.mon, 3'd0, d.day};
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mon, logic leap);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      4'd2:                    month_len = leap ? 5'd29 : 5'd28;
      default:                 month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_step.sv
module cal_time_step
  import cal_pkg::*;
(
  input  logic [WORD_W-1:0] cur_i,
  output logic [WORD_W-1:0] nxt_o,
  output logic              day_carry_o
);
  time_t c, n;
  logic  sec_wrap, min_wrap;

  always_comb begin
    c        = unpack_time(cur_i);
    n        = c;
    sec_wrap = (c.sec >= 6'd59);
    min_wrap = sec_wrap && (c.min >= 6'd59);
    day_carry_o = min_wrap && (c.hour >= 5'd23);
    n.sec = sec_wrap ? 6'd0 : c.sec + 6'd1;
    if (sec_wrap) n.min  = (c.min >= 6'd59) ? 6'd0 : c.min + 6'd1;
    if (min_wrap) n.hour = (c.hour >= 5'd23) ? 5'd0 : c.hour + 5'd1;
    nxt_o = pack_time(n);
  end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
#(
  parameter int unsigned YEAR_BASE = 1970
) (
  input  logic [WORD_W-1:0] cur_i,
  output logic [WORD_W-1:0] nxt_o
);
  localparam logic [1:0] BASE_MOD = 2'(YEAR_BASE % 4);

  date_t c, n;
  logic  [5:0] ny;

  always_comb begin
    c  = unpack_date(cur_i);
    n  = c;
    ny = c.year + 6'd1;
    if (c.day >= month_len(c.mon, c.leap)) begin
      n.day = 5'd1;
      if (c.mon >= 4'd12) begin
        n.mon  = 4'd1;
        n.year = ny;
        n.leap = ((ny[1:0] + BASE_MOD) == 2'd0);
      end else begin
        n.mon = c.mon + 4'd1;
      end
    end else begin
      n.day = c.day + 5'd1;
    end
    nxt_o = pack_date(n);
  end
endmodule

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
  parameter int unsigned W            = 32,
  parameter int unsigned COMMIT_TICKS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] value_o
);
  localparam int unsigned CNT_W = $clog2(COMMIT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_TICKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     hold_q;
  logic             accept;

  assign accept   = wr_i && !busy_q;
  assign commit_o = busy_q && tick_i && (cnt_q == LAST);
  assign busy_o   = busy_q;
  assign value_o  = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      hold_q <= data_i;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r5_set_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !busy_q |=> busy_q);
  a_r5_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> busy_q);
  a_r6_drop_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && wr_i |=> $stable(hold_q));
  a_r7_clear_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(tick_i));
endmodule

// File: rtl/cal_regs.sv
module cal_regs
  import cal_pkg::*;
#(
  parameter int unsigned COMMIT_TICKS = 2,
  parameter int unsigned YEAR_BASE    = 1970
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] time_o,
  output logic [31:0] date_o,
  output logic [1:0]  busy_o
);
  logic [WORD_W-1:0] time_q, date_q;
  logic [WORD_W-1:0] time_nxt, date_nxt;
  logic              day_carry;

  logic [WORD_W-1:0] t_val, d_val;
  logic              t_commit, d_commit, t_busy, d_busy;

  cal_time_step u_time_step (
    .cur_i       (time_q),
    .nxt_o       (time_nxt),
    .day_carry_o (day_carry)
  );

  cal_date_step #(.YEAR_BASE(YEAR_BASE)) u_date_step (
    .cur_i (date_q),
    .nxt_o (date_nxt)
  );

  cal_commit_slot #(.W(WORD_W), .COMMIT_TICKS(COMMIT_TICKS)) u_time_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_i     (wr_en_i && !wr_sel_i),
    .data_i   (wr_data_i & TIME_MASK),
    .busy_o   (t_busy),
    .commit_o (t_commit),
    .value_o  (t_val)
  );

  cal_commit_slot #(.W(WORD_W), .COMMIT_TICKS(COMMIT_TICKS)) u_date_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_i     (wr_en_i && wr_sel_i),
    .data_i   (wr_data_i & DATE_MASK),
    .busy_o   (d_busy),
    .commit_o (d_commit),
    .value_o  (d_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      date_q <= DATE_RESET;
    end else if (tick_i) begin
      time_q <= t_commit ? t_val : time_nxt;
      // the day carry comes from the stored time, even on a time commit
      if (d_commit)       date_q <= d_val;
      else if (day_carry) date_q <= date_nxt;
    end
  end

  assign time_o = time_q;
  assign date_o = date_q;
  assign busy_o = {t_busy, d_busy};

  a_r8_quiet_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_q) && $stable(date_q));
  a_r2_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !t_commit && time_q[5:0] == 6'd59 |=> time_q[5:0] == 6'd0);
  a_r3_date_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !d_commit && time_q[20:16] != 5'd23 |=> $stable(date_q));
  a_r7_commit_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && t_commit |=> time_q == $past(t_val) && !busy_o[1]);
endmodule

// File: tb/cal_regs_bench.sv
module cal_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] time_o, date_o;
  logic [1:0]  busy_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  cal_regs u_cal_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .time_o    (time_o),
    .date_o    (date_o),
    .busy_o    (busy_o)
  );

  // {time_in, date_in, time_after_tick, date_after_tick}
  localparam logic [127:0] VEC [0:12] = '{
    {32'h000C2238, 32'h005E030F, 32'h000C2239, 32'h005E030F},
    {32'h000A3B3B, 32'h005E030F, 32'h000B0000, 32'h005E030F},
    {32'h00173B3B, 32'h001D0C1F, 32'h00000000, 32'h005E0101},
    {32'h00173B3B, 32'h0076021C, 32'h00000000, 32'h0076021D},
    {32'h00173B3B, 32'h0035021C, 32'h00000000, 32'h00350301},
    {32'h00173B3B, 32'h0076021D, 32'h00000000, 32'h00760301},
    {32'h00173B3B, 32'h0035041E, 32'h00000000, 32'h00350501},
    {32'h00173B3B, 32'h0035011F, 32'h00000000, 32'h00350201},
    {32'h00173B3B, 32'h0035061E, 32'h00000000, 32'h00350701},
    {32'h00173B3B, 32'h00350B1E, 32'h00000000, 32'h00350C01},
    {32'h00173B3B, 32'h003F0C1F, 32'h00000000, 32'h00000101},
    {32'h00173B3B, 32'h00340C1F, 32'h00000000, 32'h00350101},
    {32'h00173B3B, 32'h00350C1F, 32'h00000000, 32'h00760101}
  };

  task automatic step(input logic t, input logic w, input logic s, input logic [31:0] d);
    tick_i = t; wr_en_i = w; wr_sel_i = s; wr_data_i = d;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 time", time_o, 32'h0);
    check("R1 date", date_o, 32'h00000101);
    check("R1 busy", {30'd0, busy_o}, 32'h0);

    // write with stray high bits, then a second write while busy
    step(1'b0, 1'b1, 1'b0, 32'hFFE1C2C3);
    check("R5 time busy", {30'd0, busy_o}, 32'h2);
    check("R8 no tick", time_o, 32'h0);
    step(1'b0, 1'b1, 1'b0, 32'h00050505);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    check("R7 busy after 1 tick", {30'd0, busy_o}, 32'h2);
    check("R2 advance while pending", time_o, 32'h00000001);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    check("R7 busy clear", {30'd0, busy_o}, 32'h0);
    check("R6 R7 committed masked", time_o, 32'h00010203);

    // tick in the write cycle does not count
    step(1'b1, 1'b1, 1'b1, 32'h00350101);
    check("R5 date busy", {30'd0, busy_o}, 32'h1);
    check("R2 tick on write", time_o, 32'h00010204);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    check("R7 write-cycle tick ignored", {30'd0, busy_o}, 32'h1);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    check("R7 date busy clear", {30'd0, busy_o}, 32'h0);
    check("R7 date committed", date_o, 32'h00350101);

    for (int i = 0; i < 13; i++) begin
      step(1'b0, 1'b1, 1'b0, VEC[i][127:96]);
      step(1'b0, 1'b1, 1'b1, VEC[i][95:64]);
      step(1'b1, 1'b0, 1'b0, 32'h0);
      step(1'b1, 1'b0, 1'b0, 32'h0);
      check("R7 vec load time", time_o, VEC[i][127:96]);
      check("R7 vec load date", date_o, VEC[i][95:64]);
      step(1'b1, 1'b0, 1'b0, 32'h0);
      check("R2 vec time", time_o, VEC[i][63:32]);
      check("R3 R4 vec date", date_o, VEC[i][31:0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule